// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Controller

This block owns the machine-mode trap state of a small 32-bit core with compressed instructions. It decides whether each instruction boundary carries an environment-call trap, a breakpoint trap, a return from a handler or an interrupt. It also keeps the status word, the interrupt-enable and interrupt-pending words, the saved exception PC and the cause word. Every decision appears in the same cycle as a one-cycle redirect of the program counter. Three entry points are fixed: 0x0 for reset, 0x4 for traps and 0x8 for interrupts. Nothing in the block holds a vector base.

A separate trap-enable flag sits beside the usual interrupt-enable flag. Entry into any handler clears it, and only the return from a handler sets it again. A trap raised while the flag is clear is treated as a double fault. It is not taken as a nested trap. The core restarts at the reset entry, and the saved PC and cause from the fault are kept so that boot code can inspect them.

Four interrupt sources are wired in. Two are rising-edge inputs that stay latched until software clears them. Two are level inputs from a UART, one for byte available and one for room to transmit. The core drives the boundary strobe and the request strobes, and it applies the register access requested through the CSR port.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `redirect_valid` is 1 with `redirect_pc` 0x0. After reset, the CSRs read as follows: status 0x0000000C, enable 0, saved PC 0, cause 0. Pending reads 0 while the level inputs are low.
- R2: A request on `ebreak_req` or `ecall_req` while the trap-enable flag is 1 redirects to 0x4 in the same cycle. The cause becomes 3 for a breakpoint and 11 for an environment call. The saved PC (CSR 0x341) becomes `cur_pc` with bit 0 cleared.
- R3: On entry to a trap or an interrupt, the status bits change as follows: MPIE (bit 7) takes the old MIE (bit 3), MIE becomes 0, and the trap-enable flag (bit 2) becomes 0.
- R4: A trap requested while the trap-enable flag is 0 redirects to 0x0. It writes the saved PC and cause as usual. It sets MIE and the trap-enable flag to 1, leaves MPIE unchanged, and clears the enable word and the latched edge bits.
- R5: `mret_req` redirects to the saved PC. It copies MPIE into MIE, then sets MPIE and the trap-enable flag to 1.
- R6: A rising edge on `irq_edge_in[0]` sets pending bit 16, and one on `irq_edge_in[1]` sets bit 17. Each bit stays set until a CSR write leaves a 0 in that bit position of the pending word (CSR 0x344). A set operation cannot raise a pending bit.
- R7: Pending bits 18 and 19 follow `irq_level_in[0]` and `irq_level_in[1]` directly. CSR writes have no effect on them.
- R8: An interrupt is taken at a strobe on `instr_bound` only when status MIE is 1 and (enable & pending) is nonzero. It redirects to 0x8 and saves `cur_pc`. The cause becomes 0x80000000 plus the number of the lowest pending enabled source.
- R9: The trap-enable flag cannot be changed through the CSR port. The saved PC changes only through a plain write (`csr_wr`), and its bit 0 always reads 0. The cause word (CSR 0x342) is read-only.
- R10: When several requests arrive in one cycle, a trap comes first, a return second and an interrupt third. Any of these events cancels a CSR write in the same cycle.
- R11: The CSR map is: status 0x300, enable 0x304 (bits 16 to 19 writable), saved PC 0x341, cause 0x342, pending 0x344. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_bound | input | 1 | Instruction boundary at which an interrupt may be taken |
| cur_pc | input | PC_W | PC of the trapping instruction, or of the next instruction at a boundary |
| ecall_req | input | 1 | Environment-call trap request |
| ebreak_req | input | 1 | Breakpoint trap request |
| mret_req | input | 1 | Return-from-handler strobe |
| irq_edge_in | input | N_EDGE | Edge-triggered interrupt inputs (bits 16 and up) |
| irq_level_in | input | N_LEVEL | UART byte-available and transmit-ready levels |
| csr_addr | input | 12 | CSR address, read and write |
| csr_wr | input | 1 | Plain CSR write |
| csr_set | input | 1 | CSR bit-set operation |
| csr_clr | input | 1 | CSR bit-clear operation |
| csr_wdata | input | 32 | CSR write data or mask |
| csr_rdata | output | 32 | Combinational read of the addressed CSR |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | PC_W | Redirect target |

## Verification
A wrong status bit shows up at the next boundary. A lost MIE or trap-enable flag either blocks an interrupt or turns an ordinary trap into a jump to 0x0. A corrupted MPIE appears in the status read after the next return. A latched edge bit that never clears keeps producing redirects to 0x8 after every return. Errors in the saved PC or the cause show in the very next return target and in the read one cycle after entry. The bench therefore reads every CSR straight after each event and compares the same-cycle redirect target.

// File: rtl/trap_ctrl_pkg.sv
`timescale 1ns/1ps
package trap_ctrl_pkg;
   localparam logic [11:0] CSR_STATUS  = 12'h300;
   localparam logic [11:0] CSR_ENABLE  = 12'h304;
   localparam logic [11:0] CSR_EPC     = 12'h341;
   localparam logic [11:0] CSR_CAUSE   = 12'h342;
   localparam logic [11:0] CSR_PENDING = 12'h344;

   localparam int ST_TE_BIT   = 2;
   localparam int ST_IE_BIT   = 3;
   localparam int ST_PIE_BIT  = 7;

   localparam logic [31:0] CAUSE_BREAK = 32'd3;
   localparam logic [31:0] CAUSE_ECALL = 32'd11;
   localparam logic [31:0] CAUSE_INTR  = 32'h8000_0000;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_TRAP,
      EV_DFAULT,
      EV_RET,
      EV_IRQ
   } trap_event_e;
endpackage

// File: rtl/trap_irq_src.sv
`timescale 1ns/1ps
module trap_irq_src #(
   parameter int N_EDGE      = 2,
   parameter int N_LEVEL     = 2,
   parameter int SYNC_STAGES = 0,
   localparam int N_SRC      = N_EDGE + N_LEVEL
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_EDGE-1:0]  edge_in,
   input  logic [N_LEVEL-1:0] level_in,
   input  logic [N_EDGE-1:0]  keep_mask,
   input  logic               clr_all,
   output logic [N_SRC-1:0]   pend
);
   logic [N_EDGE-1:0] edge_s;
   logic [N_EDGE-1:0] edge_prev;
   logic [N_EDGE-1:0] edge_pend;
   logic [N_EDGE-1:0] rise;

   if (SYNC_STAGES == 0) begin : g_direct
      assign edge_s = edge_in;
   end else begin : g_sync
      logic [N_EDGE-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= edge_in;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign edge_s = chain[SYNC_STAGES-1];
   end

   assign rise = edge_s & ~edge_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_prev <= '0;
         edge_pend <= '0;
      end else begin
         edge_prev <= edge_s;
         if (clr_all) edge_pend <= '0;
         else         edge_pend <= (edge_pend & keep_mask) | rise;
      end
   end

   assign pend = {level_in, edge_pend};
endmodule

// File: rtl/trap_irq_pick.sv
`timescale 1ns/1ps
module trap_irq_pick #(
   parameter int N_SRC = 4,
   localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
   import trap_ctrl_pkg::*;
#(
   parameter int          PC_W        = 28,
   parameter int          N_EDGE      = 2,
   parameter int          N_LEVEL     = 2,
   parameter int          IRQ_BASE    = 16,
   parameter int          SYNC_STAGES = 0,
   parameter logic [31:0] RESET_VEC   = 32'h0,
   parameter logic [31:0] TRAP_VEC    = 32'h4,
   parameter logic [31:0] IRQ_VEC     = 32'h8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_bound,
   input  logic [PC_W-1:0]    cur_pc,
   input  logic               ecall_req,
   input  logic               ebreak_req,
   input  logic               mret_req,
   input  logic [N_EDGE-1:0]  irq_edge_in,
   input  logic [N_LEVEL-1:0] irq_level_in,
   input  logic [11:0]        csr_addr,
   input  logic               csr_wr,
   input  logic               csr_set,
   input  logic               csr_clr,
   input  logic [31:0]        csr_wdata,
   output logic [31:0]        csr_rdata,
   output logic               redirect_valid,
   output logic [PC_W-1:0]    redirect_pc
);
   localparam int N_IRQ = N_EDGE + N_LEVEL;
   localparam int IW    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

   if (PC_W < 4 || PC_W > 32) begin : g_bad_pc_w
      $error("trap_ctrl: PC_W must lie in 4..32");
   end
   if (N_EDGE < 1 || N_LEVEL < 1 || IRQ_BASE + N_IRQ > 31) begin : g_bad_irq
      $error("trap_ctrl: interrupt field does not fit below bit 31");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("trap_ctrl: SYNC_STAGES must be non-negative");
   end

   logic              st_mie, st_mpie, st_mte, boot_q;
   logic [N_IRQ-1:0]  mie_q;
   logic [PC_W-1:0]   mepc_q;
   logic [31:0]       mcause_q;
   logic [N_IRQ-1:0]  pend;
   logic              irq_any;
   logic [IW-1:0]     irq_idx;
   logic [N_EDGE-1:0] keep_mask;
   logic [31:0]       wval;
   logic              csr_we;
   logic              trap_req;
   logic [31:0]       trap_cause, irq_cause;
   logic [PC_W-1:0]   pc_even;
   trap_event_e       ev;

   trap_irq_src #(
      .N_EDGE(N_EDGE), .N_LEVEL(N_LEVEL), .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .edge_in(irq_edge_in), .level_in(irq_level_in),
      .keep_mask(keep_mask), .clr_all(ev == EV_DFAULT), .pend(pend)
   );

   trap_irq_pick #(.N_SRC(N_IRQ)) u_pick (
      .req(pend & mie_q), .any(irq_any), .idx(irq_idx)
   );

   assign trap_req   = ecall_req | ebreak_req;
   assign trap_cause = ebreak_req ? CAUSE_BREAK : CAUSE_ECALL;
   assign irq_cause  = CAUSE_INTR | (32'(IRQ_BASE) + 32'(irq_idx));
   assign pc_even    = {cur_pc[PC_W-1:1], 1'b0};

   always_comb begin
      if (trap_req)                            ev = st_mte ? EV_TRAP : EV_DFAULT;
      else if (mret_req)                       ev = EV_RET;
      else if (instr_bound && st_mie && irq_any) ev = EV_IRQ;
      else                                     ev = EV_NONE;
   end

   always_comb begin
      case (csr_addr)
         CSR_STATUS: begin
            csr_rdata = '0;
            csr_rdata[ST_TE_BIT]  = st_mte;
            csr_rdata[ST_IE_BIT]  = st_mie;
            csr_rdata[ST_PIE_BIT] = st_mpie;
         end
         CSR_ENABLE:  csr_rdata = 32'(mie_q) << IRQ_BASE;
         CSR_PENDING: csr_rdata = 32'(pend) << IRQ_BASE;
         CSR_EPC:     csr_rdata = 32'(mepc_q);
         CSR_CAUSE:   csr_rdata = mcause_q;
         default:     csr_rdata = '0;
      endcase
   end

   always_comb begin
      if (csr_wr)       wval = csr_wdata;
      else if (csr_set) wval = csr_rdata | csr_wdata;
      else              wval = csr_rdata & ~csr_wdata;
   end
   assign csr_we = (csr_wr | csr_set | csr_clr) && (ev == EV_NONE);
   assign keep_mask = (csr_we && csr_addr == CSR_PENDING) ?
                      wval[IRQ_BASE +: N_EDGE] : '1;

   always_comb begin
      redirect_valid = boot_q || (ev != EV_NONE);
      case (ev)
         EV_TRAP: redirect_pc = TRAP_VEC[PC_W-1:0];
         EV_RET:  redirect_pc = mepc_q;
         EV_IRQ:  redirect_pc = IRQ_VEC[PC_W-1:0];
         default: redirect_pc = RESET_VEC[PC_W-1:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q   <= 1'b1;
         st_mie   <= 1'b1;
         st_mpie  <= 1'b0;
         st_mte   <= 1'b1;
         mie_q    <= '0;
         mepc_q   <= '0;
         mcause_q <= '0;
      end else begin
         boot_q <= 1'b0;
         case (ev)
            EV_TRAP, EV_IRQ: begin
               mepc_q   <= pc_even;
               mcause_q <= (ev == EV_TRAP) ? trap_cause : irq_cause;
               st_mpie  <= st_mie;
               st_mie   <= 1'b0;
               st_mte   <= 1'b0;
            end
            EV_DFAULT: begin
               mepc_q   <= pc_even;
               mcause_q <= trap_cause;
               st_mie   <= 1'b1;
               st_mte   <= 1'b1;
               mie_q    <= '0;
            end
            EV_RET: begin
               st_mie  <= st_mpie;
               st_mpie <= 1'b1;
               st_mte  <= 1'b1;
            end
            default: begin
               if (csr_we) begin
                  case (csr_addr)
                     CSR_STATUS: begin
                        st_mie  <= wval[ST_IE_BIT];
                        st_mpie <= wval[ST_PIE_BIT];
                     end
                     CSR_ENABLE: mie_q <= wval[IRQ_BASE +: N_IRQ];
                     CSR_EPC:    if (csr_wr) mepc_q <= {csr_wdata[PC_W-1:1], 1'b0};
                     default: ;
                  endcase
               end
            end
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = &{1'b0, wval, csr_wdata, cur_pc[0]};
endmodule

// File: rtl/trap_ctrl_chk.sv
`timescale 1ns/1ps
module trap_ctrl_chk #(
   parameter int          PC_W    = 28,
   parameter int          N_IRQ   = 4,
   parameter logic [31:0] IRQ_VEC = 32'h8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ecall_req,
   input logic             ebreak_req,
   input logic             mret_req,
   input logic             redirect_valid,
   input logic [PC_W-1:0]  redirect_pc,
   input logic             st_mie,
   input logic             st_mpie,
   input logic             st_mte,
   input logic [N_IRQ-1:0] mie_q
);
   logic trap;
   assign trap = ecall_req | ebreak_req;

   assert_trap_redirects_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trap && st_mte |-> redirect_valid && redirect_pc != '0);

   assert_entry_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap && st_mte |=> !st_mie && !st_mte);

   assert_double_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap && !st_mte |=> st_mte && st_mie && mie_q == '0);

   assert_return_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mret_req && !trap |=> st_mte && st_mpie);

   assert_irq_needs_mie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid && !trap && !mret_req && redirect_pc == IRQ_VEC[PC_W-1:0] |-> st_mie);

   assert_te_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !trap && !mret_req && !redirect_valid |=> $stable(st_mte));
endmodule

bind trap_ctrl trap_ctrl_chk #(.PC_W(PC_W), .N_IRQ(N_IRQ), .IRQ_VEC(IRQ_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ecall_req(ecall_req), .ebreak_req(ebreak_req),
   .mret_req(mret_req), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
   .st_mie(st_mie), .st_mpie(st_mpie), .st_mte(st_mte), .mie_q(mie_q)
);

// File: tb/trap_ctrl_tb.sv
`timescale 1ns/1ps
module trap_ctrl_tb;
   localparam int PCW = 28;
   localparam logic [11:0] A_ST = 12'h300, A_EN = 12'h304, A_EPC = 12'h341,
                           A_CA = 12'h342, A_PD = 12'h344;
   localparam int NV = 4;
   localparam logic [PCW-1:0] TV_PC [NV] = '{28'h0000100, 28'h0ABCDE2, 28'hFFFFFFE, 28'h0000002};
   localparam logic           TV_BRK[NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [31:0]    TV_CA [NV] = '{32'd11, 32'd3, 32'd3, 32'd11};

   logic clk = 0, rst_n = 0;
   logic instr_bound = 0, ecall_req = 0, ebreak_req = 0, mret_req = 0;
   logic [PCW-1:0] cur_pc = '0;
   logic [1:0] irq_edge_in = 0, irq_level_in = 0;
   logic [11:0] csr_addr = 0;
   logic csr_wr = 0, csr_set = 0, csr_clr = 0;
   logic [31:0] csr_wdata = 0, csr_rdata, v;
   logic redirect_valid;
   logic [PCW-1:0] redirect_pc;
   int n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   trap_ctrl u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] r);
      csr_addr = a; #1; r = csr_rdata;
   endtask

   task automatic csr_op(input int op, input logic [11:0] a, input logic [31:0] d);
      csr_addr = a; csr_wdata = d;
      csr_wr = (op == 0); csr_set = (op == 1); csr_clr = (op == 2);
      tick();
      csr_wr = 0; csr_set = 0; csr_clr = 0;
   endtask

   task automatic do_ret(input logic [PCW-1:0] exp_pc, input string req);
      mret_req = 1; #1;
      chk(req, 32'(redirect_pc), 32'(exp_pc));
      tick(); mret_req = 0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2; #1;
      chk("R1 boot redirect in reset", {31'b0, redirect_valid}, 1);
      rst_n = 1; #1;
      chk("R1 boot redirect", {31'b0, redirect_valid}, 1);
      chk("R1 boot target", 32'(redirect_pc), 0);
      tick();
      chk("R1 redirect drops", {31'b0, redirect_valid}, 0);
      rd(A_ST, v);  chk("R1 status", v, 32'h0C);
      rd(A_EN, v);  chk("R1 enable", v, 0);
      rd(A_PD, v);  chk("R1 pending", v, 0);
      rd(A_EPC, v); chk("R1 epc", v, 0);
      rd(A_CA, v);  chk("R1 cause", v, 0);
      rd(12'h123, v); chk("R11 unmapped", v, 0);

      // R2 R3 R5: table-driven trap then return
      for (int i = 0; i < NV; i++) begin
         cur_pc = TV_PC[i];
         ebreak_req = TV_BRK[i]; ecall_req = !TV_BRK[i]; #1;
         chk("R2 redirect", {31'b0, redirect_valid}, 1);
         chk("R2 trap vector", 32'(redirect_pc), 4);
         tick(); ebreak_req = 0; ecall_req = 0;
         rd(A_CA, v);  chk("R2 cause", v, TV_CA[i]);
         rd(A_EPC, v); chk("R2 epc", v, 32'(TV_PC[i]) & ~32'h1);
         rd(A_ST, v);  chk("R3 status on entry", v, 32'h80);
         do_ret(TV_PC[i] & ~28'h1, "R5 return target");
         rd(A_ST, v);  chk("R5 status after return", v, 32'h8C);
      end

      // R6 edge latching, set op cannot raise
      csr_op(0, A_EN, 32'h000F_0000);
      irq_edge_in = 2'b01; tick(); irq_edge_in = 0;
      rd(A_PD, v); chk("R6 edge0 latched", v, 32'h1_0000);
      csr_op(1, A_PD, 32'h2_0000);
      rd(A_PD, v); chk("R6 set op ignored", v, 32'h1_0000);

      // R4 double fault
      cur_pc = 28'h40; ecall_req = 1; tick(); ecall_req = 0;
      cur_pc = 28'h44; ebreak_req = 1; #1;
      chk("R4 fault target", 32'(redirect_pc), 0);
      tick(); ebreak_req = 0;
      rd(A_CA, v);  chk("R4 cause", v, 3);
      rd(A_EPC, v); chk("R4 epc", v, 32'h44);
      rd(A_ST, v);  chk("R4 status", v, 32'h8C);
      rd(A_EN, v);  chk("R4 enable cleared", v, 0);
      rd(A_PD, v);  chk("R4 pending cleared", v, 0);

      // R6 clear by write
      irq_edge_in = 2'b10; tick(); irq_edge_in = 0;
      rd(A_PD, v); chk("R6 edge1 latched", v, 32'h2_0000);
      csr_op(0, A_PD, 0);
      rd(A_PD, v); chk("R6 cleared by write", v, 0);

      // R7 levels
      irq_level_in = 2'b01;
      rd(A_PD, v); chk("R7 rx level", v, 32'h4_0000);
      csr_op(2, A_PD, 32'h4_0000);
      rd(A_PD, v); chk("R7 clear ignored", v, 32'h4_0000);
      irq_level_in = 2'b10;
      rd(A_PD, v); chk("R7 tx level", v, 32'h8_0000);
      irq_level_in = 0;

      // R8 interrupt take, lowest wins
      csr_op(0, A_EN, 32'h0003_0000);
      irq_edge_in = 2'b11; tick(); irq_edge_in = 0;
      cur_pc = 28'h120; instr_bound = 1; #1;
      chk("R8 irq redirect", {31'b0, redirect_valid}, 1);
      chk("R8 irq vector", 32'(redirect_pc), 8);
      tick(); instr_bound = 0;
      rd(A_CA, v);  chk("R8 lowest cause", v, 32'h8000_0010);
      rd(A_EPC, v); chk("R8 epc", v, 32'h120);
      rd(A_ST, v);  chk("R3 status on irq", v, 32'h80);
      instr_bound = 1; #1;
      chk("R8 gated by MIE", {31'b0, redirect_valid}, 0);
      instr_bound = 0;
      csr_op(0, A_PD, 32'h2_0000);
      rd(A_PD, v); chk("R6 selective clear", v, 32'h2_0000);

      // R10 priority
      cur_pc = 28'h200; instr_bound = 1; mret_req = 1; #1;
      chk("R10 return beats irq", 32'(redirect_pc), 32'h120);
      tick(); instr_bound = 0; mret_req = 0;
      cur_pc = 28'h300; instr_bound = 1; ecall_req = 1; #1;
      chk("R10 trap beats irq", 32'(redirect_pc), 4);
      tick(); instr_bound = 0; ecall_req = 0;
      rd(A_CA, v); chk("R10 trap cause", v, 11);
      do_ret(28'h300, "R5 return target");
      cur_pc = 28'h310; instr_bound = 1; #1;
      chk("R8 irq17 vector", 32'(redirect_pc), 8);
      tick(); instr_bound = 0;
      rd(A_CA, v); chk("R8 cause 17", v, 32'h8000_0011);
      do_ret(28'h310, "R5 return target");
      csr_op(0, A_PD, 0);
      csr_op(0, A_EN, 0);

      // R9 read-only and write-only-by-plain-write
      csr_op(0, A_ST, 0);
      rd(A_ST, v); chk("R9 trap-enable held", v, 32'h04);
      csr_op(1, A_ST, 32'h88);
      rd(A_ST, v); chk("R9 status set", v, 32'h8C);
      csr_op(0, A_EPC, 32'h1235);
      rd(A_EPC, v); chk("R9 epc write", v, 32'h1234);
      csr_op(1, A_EPC, 32'hFF);
      rd(A_EPC, v); chk("R9 epc set ignored", v, 32'h1234);
      csr_op(2, A_EPC, 32'h1234);
      rd(A_EPC, v); chk("R9 epc clear ignored", v, 32'h1234);
      csr_op(0, A_CA, 32'h5);
      rd(A_CA, v); chk("R9 cause read-only", v, 32'h8000_0011);

      // R10 event cancels CSR write
      cur_pc = 28'h500; ebreak_req = 1;
      csr_addr = A_EPC; csr_wdata = 32'h777; csr_wr = 1;
      tick(); ebreak_req = 0; csr_wr = 0;
      rd(A_EPC, v); chk("R10 write cancelled", v, 32'h500);
      do_ret(28'h500, "R5 return target");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule